// File: doc/BRIEF.md
# Fan Tachometer and Temperature Monitor Register Bank

This block is a small hardware-monitor register bank. A host reaches it through two byte-wide I/O locations. The even location holds a register number. The odd location reads or writes the register that number selects. Behind the pair sit four fan period counters and four temperature holding registers.

Each fan input is synchronised into the clock domain, and each rising edge marks one revolution. Between revolutions, a 16-bit counter counts reference ticks, which are about 90 kHz and come from a divider of the system clock. On every revolution edge the count moves into a readable register. The host reads that value as two bytes, low byte first. Reading the low byte freezes the matching high byte, so the two halves always belong to the same measurement. Speed in RPM is 60 divided by (count × tick period): at 11.111 µs per tick, a count of 2203 means roughly 2451 RPM.

Temperatures arrive from an external sensor interface, one channel at a time, and are held as whole degrees Celsius (0x2A reads as 42 °C).

Top module: `fan_tach_hwm`

## Requirements
- R1: A host write to address BASE_ADDR loads the 8-bit index register. A host read of BASE_ADDR returns the index. The index is 0x00 after reset.
- R2: Only BASE_ADDR and BASE_ADDR+1 respond. A read of any other address returns 0x00. A write to any other address changes no register.
- R3: A pulse on `temp_load` stores `temp_data` into channel `temp_sel`. Channels 0, 1, 2 and 3 read back through BASE_ADDR+1 at indices 0x25, 0x26, 0x27 and 0x80.
- R4: Fan n (0..3) is read at index 0x28+2n for bits 7:0 and at index 0x29+2n for bits 15:8.
- R5: After a rising edge on `tach_in[n]`, fan n reads the number of reference ticks counted between that edge and the previous one. With TICK_DIV=1, that number is the count of clock cycles between the two edges.
- R6: Reading a fan's low byte captures that fan's current high byte. A later high-byte read returns the captured byte, even if a newer revolution has been measured since.
- R7: Without edges, the running count stops at 0xFFFF. Once it gets there, the fan reads 0xFFFF without needing another edge.
- R8: A data-port read of any index that is not a temperature or fan index returns 0x00.
- R9: Data-port writes leave the fan and temperature registers unchanged.
- R10: After reset, all temperature and fan registers read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 16 | Host I/O address |
| io_wr | input | 1 | Host write strobe, one cycle per access |
| io_rd | input | 1 | Host read strobe, one cycle per access |
| io_wdata | input | 8 | Host write data |
| io_rdata | output | 8 | Host read data, valid while io_rd is high |
| tach_in | input | 4 | Asynchronous fan tachometer inputs, one per fan |
| temp_data | input | 8 | Temperature value from the sensor interface |
| temp_sel | input | 2 | Temperature channel to load |
| temp_load | input | 1 | Load strobe for temp_data |

## Verification
The assertions assume that the host never raises `io_rd` and `io_wr` in the same cycle. They also assume that every tachometer high or low phase lasts at least two clock cycles, so the synchroniser sees each edge exactly once. The bench meets both assumptions. Its bus tasks issue one strobe per cycle, and each tachometer pulse is held high for two cycles and then low for at least several more. Temperature loads are single-cycle strobes whose channel and value are held steady for that cycle.

// File: rtl/fan_tach_hwm.sv
module fan_tach_hwm #(
  parameter logic [15:0] BASE_ADDR = 16'h0480,
  parameter int          TICK_DIV  = 1389
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] io_addr,
  input  logic        io_wr,
  input  logic        io_rd,
  input  logic [7:0]  io_wdata,
  output logic [7:0]  io_rdata,
  input  logic [3:0]  tach_in,
  input  logic [7:0]  temp_data,
  input  logic [1:0]  temp_sel,
  input  logic        temp_load
);
  localparam int NFAN  = 4;
  localparam int CW    = 16;
  localparam int DIV_W = $clog2(TICK_DIV + 1);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  logic [DIV_W-1:0] div_q;
  logic             tick;
  logic [7:0]       idx_q;
  logic             win_hit, at_idx, at_data;
  logic             fan_hit, fan_hi;
  logic [1:0]       fan_num;
  logic [NFAN-1:0][CW-1:0] cnt_run, cnt_cap;
  logic [NFAN-1:0][7:0]    hold_q;
  logic [NFAN-1:0]         tach_edge;
  logic [3:0][7:0]         temp_q;
  logic [7:0]              data_val;

  assign tick = (div_q == DIV_W'(TICK_DIV - 1));

  always_ff @(posedge clk)
    if (!rst_n || tick) div_q <= '0;
    else                div_q <= div_q + 1'b1;

  assign win_hit = (io_addr[15:1] == BASE_ADDR[15:1]);
  assign at_idx  = win_hit & ~io_addr[0];
  assign at_data = win_hit &  io_addr[0];

  always_ff @(posedge clk)
    if (!rst_n)               idx_q <= 8'h00;
    else if (io_wr && at_idx) idx_q <= io_wdata;

  assign fan_hit = (idx_q[7:3] == 5'b00101);
  assign fan_num = idx_q[2:1];
  assign fan_hi  = idx_q[0];

  for (genvar g = 0; g < NFAN; g++) begin : g_fan
    logic [2:0] sync_q;
    logic       low_rd;

    always_ff @(posedge clk)
      if (!rst_n) sync_q <= 3'b000;
      else        sync_q <= {sync_q[1:0], tach_in[g]};

    assign tach_edge[g] = sync_q[1] & ~sync_q[2];
    assign low_rd = io_rd & at_data & fan_hit & ~fan_hi & (fan_num == 2'(g));

    always_ff @(posedge clk)
      if (!rst_n) begin
        cnt_run[g] <= '0;
        cnt_cap[g] <= '0;
      end else if (tach_edge[g]) begin
        cnt_cap[g] <= (tick && cnt_run[g] != CMAX) ? cnt_run[g] + 1'b1 : cnt_run[g];
        cnt_run[g] <= '0;
      end else if (tick && cnt_run[g] != CMAX) begin
        cnt_run[g] <= cnt_run[g] + 1'b1;
        if (cnt_run[g] == CMAX - 1'b1) cnt_cap[g] <= CMAX;
      end

    always_ff @(posedge clk)
      if (!rst_n)      hold_q[g] <= 8'h00;
      else if (low_rd) hold_q[g] <= cnt_cap[g][15:8];
  end

  always_ff @(posedge clk)
    if (!rst_n)         temp_q <= '0;
    else if (temp_load) temp_q[temp_sel] <= temp_data;

  always_comb begin
    data_val = 8'h00;
    case (idx_q)
      8'h25:   data_val = temp_q[0];
      8'h26:   data_val = temp_q[1];
      8'h27:   data_val = temp_q[2];
      8'h80:   data_val = temp_q[3];
      default: if (fan_hit) data_val = fan_hi ? hold_q[fan_num] : cnt_cap[fan_num][7:0];
    endcase
  end

  assign io_rdata = !io_rd  ? 8'h00 :
                    at_idx  ? idx_q :
                    at_data ? data_val : 8'h00;
endmodule

// File: rtl/fan_tach_hwm_chk.sv
module fan_tach_hwm_chk #(
  parameter logic [15:0] BASE_ADDR = 16'h0480
) (
  input logic              clk,
  input logic              rst_n,
  input logic [15:0]       io_addr,
  input logic              io_wr,
  input logic              io_rd,
  input logic [7:0]        io_wdata,
  input logic [7:0]        io_rdata,
  input logic [7:0]        idx_q,
  input logic [3:0][15:0]  cnt_run,
  input logic [3:0][15:0]  cnt_cap,
  input logic [3:0][7:0]   hold_q,
  input logic [3:0]        tach_edge,
  input logic [3:0][7:0]   temp_q,
  input logic              temp_load
);
  logic [15:0] a_idx, a_dat;
  logic        known;
  assign a_idx = {BASE_ADDR[15:1], 1'b0};
  assign a_dat = {BASE_ADDR[15:1], 1'b1};
  assign known = (idx_q inside {8'h25, 8'h26, 8'h27, 8'h80}) ||
                 (idx_q >= 8'h28 && idx_q <= 8'h2F);

  p_index_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    io_wr && io_addr == a_idx |=> idx_q == $past(io_wdata));

  p_outside_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    io_rd && io_addr != a_idx && io_addr != a_dat |-> io_rdata == 8'h00);

  p_hold_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
    io_rd && io_addr == a_dat && idx_q == 8'h28 |=> hold_q[0] == $past(cnt_cap[0][15:8]));

  p_high_from_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    io_rd && io_addr == a_dat && idx_q == 8'h29 |-> io_rdata == hold_q[0]);

  p_saturate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_run[0] == 16'hFFFF && !tach_edge[0] |=> cnt_run[0] == 16'hFFFF);

  p_unimpl_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    io_rd && io_addr == a_dat && !known |-> io_rdata == 8'h00);

  p_temp_ro_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !temp_load |=> $stable(temp_q));
endmodule

bind fan_tach_hwm fan_tach_hwm_chk #(.BASE_ADDR(BASE_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
  .io_wdata(io_wdata), .io_rdata(io_rdata), .idx_q(idx_q), .cnt_run(cnt_run),
  .cnt_cap(cnt_cap), .hold_q(hold_q), .tach_edge(tach_edge), .temp_q(temp_q),
  .temp_load(temp_load)
);

// File: tb/tb_fan_tach_hwm.sv
module tb_fan_tach_hwm;
  localparam logic [15:0] BASE = 16'h0480;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] io_addr = 16'h0000;
  logic        io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0]  io_wdata = 8'h00;
  logic [7:0]  io_rdata;
  logic [3:0]  tach_in = 4'h0;
  logic [7:0]  temp_data = 8'h00;
  logic [1:0]  temp_sel = 2'd0;
  logic        temp_load = 1'b0;

  int n_vec = 0, n_err = 0;
  bit done = 0;
  longint cyc = 0;
  longint last_rise [4];
  int     exp_cnt [4];
  logic [7:0] tmodel [4];

  fan_tach_hwm #(.BASE_ADDR(BASE), .TICK_DIV(1)) dut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .tach_in(tach_in),
    .temp_data(temp_data), .temp_sel(temp_sel), .temp_load(temp_load));

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] temp_index(input int ch);
    return (ch == 3) ? 8'h80 : 8'(8'h25 + ch);
  endfunction

  function automatic bit implemented(input logic [7:0] i);
    return (i inside {8'h25, 8'h26, 8'h27, 8'h80}) || (i >= 8'h28 && i <= 8'h2F);
  endfunction

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk); io_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk); io_addr = a; io_rd = 1'b1;
    #1 d = io_rdata;
    @(negedge clk); io_rd = 1'b0;
  endtask

  task automatic reg_read(input logic [7:0] i, output logic [7:0] d);
    bus_write(BASE, i);
    bus_read(BASE + 16'd1, d);
  endtask

  task automatic temp_put(input int ch, input logic [7:0] v);
    @(negedge clk); temp_sel = 2'(ch); temp_data = v; temp_load = 1'b1;
    @(negedge clk); temp_load = 1'b0;
    tmodel[ch] = v;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rise(input int f);
    @(negedge clk);
    exp_cnt[f] = (cyc - last_rise[f] > 65535) ? 65535 : int'(cyc - last_rise[f]);
    last_rise[f] = cyc;
    tach_in[f] = 1'b1;
    idle(2);
    tach_in[f] = 1'b0;
    idle(3);
  endtask

  task automatic fan_check(input int f, input string tag);
    logic [7:0] lo, hi;
    reg_read(8'(8'h28 + 2 * f), lo);
    reg_read(8'(8'h29 + 2 * f), hi);
    chk({tag, " low"},  lo, exp_cnt[f][7:0]);
    chk({tag, " high"}, hi, exp_cnt[f][15:8]);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, held;
    void'($urandom(32'd20231));
    for (int i = 0; i < 4; i++) begin last_rise[i] = 0; exp_cnt[i] = 0; tmodel[i] = 8'h00; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    bus_read(BASE, d);          chk("R10 index after reset", d, 8'h00);
    reg_read(8'h25, d);         chk("R10 temp0 after reset", d, 8'h00);
    reg_read(8'h80, d);         chk("R10 temp3 after reset", d, 8'h00);
    reg_read(8'h2A, d);         chk("R10 fan1 low after reset", d, 8'h00);

    bus_write(BASE, 8'h5C);
    bus_read(BASE, d);          chk("R1 index readback", d, 8'h5C);

    temp_put(0, 8'h2A);
    reg_read(8'h25, d);         chk("R3 temp0 42C", d, 8'h2A);
    for (int k = 0; k < 8; k++) begin
      int ch = $urandom % 4;
      temp_put(ch, 8'($urandom));
      reg_read(temp_index(ch), d); chk("R3 temp random", d, tmodel[ch]);
    end
    for (int ch = 0; ch < 4; ch++) begin
      bus_write(BASE, temp_index(ch));
      bus_write(BASE + 16'd1, ~tmodel[ch]);
      bus_read(BASE + 16'd1, d); chk("R9 temp write ignored", d, tmodel[ch]);
    end

    for (int k = 0; k < 10; k++) begin
      logic [7:0] i;
      do i = 8'($urandom); while (implemented(i));
      bus_write(BASE, i);
      bus_write(BASE + 16'd1, 8'hA5);
      bus_read(BASE + 16'd1, d); chk("R8 unimplemented index", d, 8'h00);
    end

    bus_write(BASE, 8'h25);
    bus_read(16'h0482, d);      chk("R2 read outside window", d, 8'h00);
    bus_write(16'h047F, 8'h80);
    bus_write(16'h0482, 8'h80);
    bus_read(BASE, d);          chk("R2 write outside window", d, 8'h25);

    for (int k = 0; k < 16; k++) begin
      int f = $urandom % 4;
      int p = 100 + ($urandom % 1400);
      rise(f);
      idle(p);
      rise(f);
      fan_check(f, "R4 R5 random period");
    end

    rise(1); idle(300); rise(1);
    reg_read(8'h2A, d);         chk("R6 low before update", d, exp_cnt[1][7:0]);
    held = exp_cnt[1][15:8];
    idle(700); rise(1);
    reg_read(8'h2B, d);         chk("R6 high returns held byte", d, held);
    fan_check(1, "R6 fresh pair");

    bus_write(BASE, 8'h2A);
    bus_write(BASE + 16'd1, 8'hFF);
    bus_read(BASE + 16'd1, d);  chk("R9 fan write ignored", d, exp_cnt[1][7:0]);

    idle(66000);
    reg_read(8'h2E, d);         chk("R7 stopped fan low", d, 8'hFF);
    reg_read(8'h2F, d);         chk("R7 stopped fan high", d, 8'hFF);
    rise(3);
    fan_check(3, "R7 edge after saturation");

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end
endmodule